// File: doc/BRIEF.md
# Multi-Latency Pipeline Hazard Interlock

This block decides, each cycle, whether the instruction sitting in the register-read stage of a single-issue, five-stage in-order pipeline may move into execute. It is also the place that chooses where each of that instruction's operands comes from. The pipeline feeds several pipelined functional units of unequal latency: two integer units that take one cycle, one floating-point unit that takes four cycles, and two memory pipes that take two cycles. Inside the block, every unit is modelled only as a shift register that carries a valid bit and a destination register ID. Each slot of that shift register stands for one execute stage plus a final writeback stage.

The instruction in register read is offered on a valid/ready pair. `rr_ready` low is the stall. While it is low, the instruction must be held unchanged at the inputs, and nothing enters execute in that cycle, which puts a bubble into execute. The instruction is accepted into the first execute stage of the unit named by `rr_unit` on any clock edge where both `rr_valid` and `rr_ready` are high. Instructions already in a unit always advance one stage per cycle and are never held.

Each source ID is compared against every tracked stage, and the same comparator outputs drive both the stall decision and the bypass choice. A match against an execute stage that has not finished yet stalls the instruction. A match against a unit's last execute stage or its writeback stage is forwarded. The destination ID is also checked against the unfinished execute stages, which prevents an older, slower instruction from overwriting a younger result.

Top module: `hz_interlock`

## Requirements
- R1: After reset no stage holds a tracked destination. Any instruction then sees `rr_ready` high and both bypass hit outputs low.
- R2: A used source that matches a tracked destination in an execute stage before a unit's final one drives `rr_ready` low. Those stages are floating-point stages 1 to 3 and memory stage 1.
- R3: A used source that matches a unit's final execute stage or its writeback stage sets that source's hit output, gives the unit index on its unit output and sets its wb output. The wb output is 1 for the writeback stage and 0 for the final execute stage. With no such match, hit, unit and wb are all 0. Unit indices are 0 and 1 for the integer units, 2 for the floating-point unit, and 3 and 4 for the memory pipes.
- R4: When several forwardable stages match one source, the bypass names the youngest producer, meaning the most recently accepted instruction.
- R5: A written destination that matches floating-point execute stages 1 to 3 or memory execute stage 1 drives `rr_ready` low. Integer-unit stages never cause this stall.
- R6: Comparisons ignore sources whose use bit is 0 and instructions whose destination-write bit is 0. Register 0 is never tracked or matched.
- R7: While `rr_ready` is low no instruction enters execute, and instructions already in the units keep advancing.
- R8: An instruction is accepted only on an edge with `rr_valid` and `rr_ready` both high. It then appears in stage 1 of unit `rr_unit` and moves one stage per cycle through to writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rr_valid | input | 1 | Register-read stage holds an instruction |
| rr_ready | output | 1 | No hazard; instruction may enter execute |
| rr_unit | input | 3 | Target functional unit index |
| rr_src_a | input | 5 | First source register ID |
| rr_use_a | input | 1 | First source is read |
| rr_src_b | input | 5 | Second source register ID |
| rr_use_b | input | 1 | Second source is read |
| rr_dst | input | 5 | Destination register ID |
| rr_dst_we | input | 1 | Instruction writes its destination |
| byp_a_hit | output | 1 | First source is taken from a bypass |
| byp_a_unit | output | 3 | Unit supplying the first source |
| byp_a_wb | output | 1 | First source comes from writeback (1) or final execute (0) |
| byp_b_hit | output | 1 | Second source is taken from a bypass |
| byp_b_unit | output | 3 | Unit supplying the second source |
| byp_b_wb | output | 1 | Second source comes from writeback (1) or final execute (0) |

## Verification
The bench builds the block with its default parameters: two one-cycle integer units, one four-cycle floating-point unit, two two-cycle memory pipes, 5-bit register IDs and register 0 excluded. With these values the bench can hold a producer in every unfinished floating-point and memory stage, which exercises the multi-cycle stall windows for both read-after-write and write-after-write. It can also place the same register in two units at once, so the youngest-producer choice is exercised against integer, memory and floating-point producers of different ages.

// File: rtl/hz_pkg.sv
package hz_pkg;

  // Latency of unit u: integer units first, then the FP unit, then memory pipes.
  function automatic int unit_lat(input int u, input int n_int,
                                  input int lat_int, input int lat_fp,
                                  input int lat_mem);
    if (u < n_int)       return lat_int;
    else if (u == n_int) return lat_fp;
    else                 return lat_mem;
  endfunction

  function automatic int max_lat(input int lat_int, input int lat_fp,
                                 input int lat_mem);
    int m;
    m = lat_int;
    if (lat_fp > m)  m = lat_fp;
    if (lat_mem > m) m = lat_mem;
    return m;
  endfunction

endpackage

// File: rtl/hz_unit_track.sv
module hz_unit_track #(
  parameter int RW      = 5,
  parameter int UW      = 3,
  parameter int LAT     = 2,
  parameter int UID     = 0,
  parameter bit SKIP_R0 = 1'b1,
  localparam int D      = LAT + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  iss_go,
  input  logic [UW-1:0]         iss_unit,
  input  logic [RW-1:0]         iss_dst,
  input  logic                  iss_we,
  output logic [D-1:0]          slot_v,
  output logic [D-1:0][RW-1:0]  slot_id
);

  logic load;
  assign load = iss_go && (iss_unit == UW'(UID)) && iss_we &&
                !(SKIP_R0 && (iss_dst == '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_v  <= '0;
      slot_id <= '0;
    end else begin
      slot_v[0]  <= load;
      slot_id[0] <= load ? iss_dst : '0;
      for (int k = 1; k < D; k++) begin
        slot_v[k]  <= slot_v[k-1];
        slot_id[k] <= slot_id[k-1];
      end
    end
  end

  // R8: an accepted writing instruction shows up in stage 1 of its unit
  p_e1_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_go && iss_unit == UW'(UID) && iss_we && iss_dst != '0)
      |=> (slot_v[0] && slot_id[0] == $past(iss_dst)));

  // R7: in-flight work never stalls, it moves one stage per cycle
  for (genvar k = 1; k < D; k++) begin : g_adv
    p_advance_r7: assert property (@(posedge clk) disable iff (!rst_n)
      slot_v[k-1] |=> (slot_v[k] && slot_id[k] == $past(slot_id[k-1])));
  end

endmodule

// File: rtl/hz_src_match.sv
module hz_src_match #(
  parameter int RW  = 5,
  parameter int LAT = 2,
  localparam int D  = LAT + 1
) (
  input  logic [RW-1:0]        reg_id,
  input  logic                 use_it,
  input  logic [D-1:0]         slot_v,
  input  logic [D-1:0][RW-1:0] slot_id,
  output logic                 early_hit,
  output logic                 fin_hit,
  output logic                 wb_hit
);

  logic [D-1:0] eq;

  for (genvar k = 0; k < D; k++) begin : g_cmp
    assign eq[k] = use_it && slot_v[k] && (slot_id[k] == reg_id);
  end

  always_comb begin
    early_hit = 1'b0;
    for (int k = 0; k < LAT - 1; k++) early_hit = early_hit | eq[k];
  end

  assign fin_hit = eq[LAT-1];
  assign wb_hit  = eq[LAT];

endmodule

// File: rtl/hz_byp_pick.sv
module hz_byp_pick #(
  parameter int NU      = 5,
  parameter int UW      = 3,
  parameter int N_INT   = 2,
  parameter int LAT_INT = 1,
  parameter int LAT_FP  = 4,
  parameter int LAT_MEM = 2
) (
  input  logic [NU-1:0] fin,
  input  logic [NU-1:0] wb,
  output logic          hit,
  output logic [UW-1:0] unit,
  output logic          from_wb
);

  // Age of a producer = cycles since it was accepted; smallest age wins.
  always_comb begin
    int best;
    int lat;
    best    = 1 << 16;
    hit     = 1'b0;
    unit    = '0;
    from_wb = 1'b0;
    for (int u = 0; u < NU; u++) begin
      lat = hz_pkg::unit_lat(u, N_INT, LAT_INT, LAT_FP, LAT_MEM);
      if (fin[u] && lat < best) begin
        best = lat; hit = 1'b1; unit = UW'(u); from_wb = 1'b0;
      end
      if (wb[u] && (lat + 1) < best) begin
        best = lat + 1; hit = 1'b1; unit = UW'(u); from_wb = 1'b1;
      end
    end
  end

endmodule

// File: rtl/hz_interlock.sv
module hz_interlock #(
  parameter int RW      = 5,
  parameter int N_INT   = 2,
  parameter int N_MEM   = 2,
  parameter int LAT_INT = 1,
  parameter int LAT_FP  = 4,
  parameter int LAT_MEM = 2,
  parameter bit SKIP_R0 = 1'b1,
  localparam int NU     = N_INT + 1 + N_MEM,
  localparam int UW     = $clog2(NU)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rr_valid,
  output logic          rr_ready,
  input  logic [UW-1:0] rr_unit,
  input  logic [RW-1:0] rr_src_a,
  input  logic          rr_use_a,
  input  logic [RW-1:0] rr_src_b,
  input  logic          rr_use_b,
  input  logic [RW-1:0] rr_dst,
  input  logic          rr_dst_we,
  output logic          byp_a_hit,
  output logic [UW-1:0] byp_a_unit,
  output logic          byp_a_wb,
  output logic          byp_b_hit,
  output logic [UW-1:0] byp_b_unit,
  output logic          byp_b_wb
);

  logic [NU-1:0] early_a, fin_a, wb_a;
  logic [NU-1:0] early_b, fin_b, wb_b;
  logic [NU-1:0] early_d, fin_d, wb_d;
  logic [NU-1:0] e1_v;
  logic          go;

  assign go = rr_valid && rr_ready;

  for (genvar u = 0; u < NU; u++) begin : g_unit
    localparam int L = hz_pkg::unit_lat(u, N_INT, LAT_INT, LAT_FP, LAT_MEM);
    logic [L:0]         sv;
    logic [L:0][RW-1:0] sid;

    hz_unit_track #(.RW(RW), .UW(UW), .LAT(L), .UID(u), .SKIP_R0(SKIP_R0)) u_trk (
      .clk(clk), .rst_n(rst_n), .iss_go(go), .iss_unit(rr_unit),
      .iss_dst(rr_dst), .iss_we(rr_dst_we), .slot_v(sv), .slot_id(sid));

    hz_src_match #(.RW(RW), .LAT(L)) u_ma (
      .reg_id(rr_src_a), .use_it(rr_use_a), .slot_v(sv), .slot_id(sid),
      .early_hit(early_a[u]), .fin_hit(fin_a[u]), .wb_hit(wb_a[u]));

    hz_src_match #(.RW(RW), .LAT(L)) u_mb (
      .reg_id(rr_src_b), .use_it(rr_use_b), .slot_v(sv), .slot_id(sid),
      .early_hit(early_b[u]), .fin_hit(fin_b[u]), .wb_hit(wb_b[u]));

    // destination vs. unfinished stages: write-after-write window
    hz_src_match #(.RW(RW), .LAT(L)) u_md (
      .reg_id(rr_dst), .use_it(rr_dst_we), .slot_v(sv), .slot_id(sid),
      .early_hit(early_d[u]), .fin_hit(fin_d[u]), .wb_hit(wb_d[u]));

    assign e1_v[u] = sv[0];
  end

  assign rr_ready = !(|early_a || |early_b || |early_d);

  hz_byp_pick #(.NU(NU), .UW(UW), .N_INT(N_INT), .LAT_INT(LAT_INT),
                .LAT_FP(LAT_FP), .LAT_MEM(LAT_MEM)) u_pick_a (
    .fin(fin_a), .wb(wb_a), .hit(byp_a_hit), .unit(byp_a_unit), .from_wb(byp_a_wb));

  hz_byp_pick #(.NU(NU), .UW(UW), .N_INT(N_INT), .LAT_INT(LAT_INT),
                .LAT_FP(LAT_FP), .LAT_MEM(LAT_MEM)) u_pick_b (
    .fin(fin_b), .wb(wb_b), .hit(byp_b_hit), .unit(byp_b_unit), .from_wb(byp_b_wb));

  // R8: single issue, so at most one unit receives work per cycle
  p_single_e1_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(e1_v));

  // R7: a held instruction leaves a bubble in execute
  p_bubble_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rr_valid && !rr_ready) |=> (e1_v == '0));

endmodule

// File: tb/tb_hz_interlock.sv
module tb_hz_interlock;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rr_valid = 1'b0, rr_ready;
  logic [2:0] rr_unit = '0;
  logic [4:0] rr_src_a = '0, rr_src_b = '0, rr_dst = '0;
  logic       rr_use_a = 1'b0, rr_use_b = 1'b0, rr_dst_we = 1'b0;
  logic       byp_a_hit, byp_a_wb, byp_b_hit, byp_b_wb;
  logic [2:0] byp_a_unit, byp_b_unit;

  always #10 clk = ~clk;

  hz_interlock dut (
    .clk(clk), .rst_n(rst_n), .rr_valid(rr_valid), .rr_ready(rr_ready),
    .rr_unit(rr_unit), .rr_src_a(rr_src_a), .rr_use_a(rr_use_a),
    .rr_src_b(rr_src_b), .rr_use_b(rr_use_b), .rr_dst(rr_dst),
    .rr_dst_we(rr_dst_we), .byp_a_hit(byp_a_hit), .byp_a_unit(byp_a_unit),
    .byp_a_wb(byp_a_wb), .byp_b_hit(byp_b_hit), .byp_b_unit(byp_b_unit),
    .byp_b_wb(byp_b_wb));

  typedef struct {
    logic [8:0] val;   // {ready, ah, au[2:0], aw, bh, bu...} packed below
    logic [2:0] bu;
    logic       bw;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   n_run = 0, n_fail = 0;
  bit   done = 1'b0;

  task automatic step(input bit v, input logic [2:0] un,
                      input logic [4:0] sa, input bit ua,
                      input logic [4:0] sb, input bit ub,
                      input logic [4:0] d, input bit we,
                      input bit er, input bit eah, input logic [2:0] eau, input bit eaw,
                      input bit ebh, input logic [2:0] ebu, input bit ebw,
                      input string tag);
    exp_t e;
    @(posedge clk);
    #2;
    rr_valid = v; rr_unit = un; rr_src_a = sa; rr_use_a = ua;
    rr_src_b = sb; rr_use_b = ub; rr_dst = d; rr_dst_we = we;
    e.val = {1'b0, er, eah, eau, eaw, ebh};
    e.bu = ebu; e.bw = ebw; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compare mid-cycle, after inputs settled
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        logic [8:0] act;
        e = q.pop_front();
        act = {1'b0, rr_ready, byp_a_hit, byp_a_unit, byp_a_wb, byp_b_hit};
        n_run++;
        if (act !== e.val || byp_b_unit !== e.bu || byp_b_wb !== e.bw) begin
          n_fail++;
          $display("FAIL %s: actual rdy/ah/au/aw/bh=%b bu=%0d bw=%b expected %b bu=%0d bw=%b",
                   e.tag, act[7:0], byp_b_unit, byp_b_wb, e.val[7:0], e.bu, e.bw);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    //   v un  sa ua sb ub  d  we   rdy ah au aw  bh bu bw
    step(1, 0,  5, 1, 6, 1,  7, 1,  1, 0, 0, 0,  0, 0, 0, "R1 reset empty");
    step(1, 1,  7, 1, 8, 1,  9, 1,  1, 1, 0, 0,  0, 0, 0, "R3 int final-exec fwd");
    step(1, 3,  7, 1, 9, 1, 10, 1,  1, 1, 0, 1,  1, 1, 0, "R3 int wb and exec fwd");
    step(1, 0, 10, 1, 0, 0, 11, 1,  0, 0, 0, 0,  0, 0, 0, "R2 mem E1 raw stall");
    step(1, 0, 10, 1, 0, 0, 11, 1,  1, 1, 3, 0,  0, 0, 0, "R7 R8 held then mem E2 fwd");
    step(1, 2, 10, 1, 11, 1, 12, 1, 1, 1, 3, 1,  1, 0, 0, "R3 mem wb fwd");
    step(1, 0, 12, 0, 0, 0, 12, 1,  0, 0, 0, 0,  0, 0, 0, "R5 R6 waw fp E1 unused src");
    step(1, 0, 12, 0, 0, 0, 12, 1,  0, 0, 0, 0,  0, 0, 0, "R5 waw fp E2");
    step(1, 0, 12, 0, 0, 0, 12, 1,  0, 0, 0, 0,  0, 0, 0, "R5 waw fp E3");
    step(1, 0, 12, 0, 0, 0, 12, 1,  1, 0, 0, 0,  0, 0, 0, "R5 fp E4 outside waw");
    step(1, 1, 12, 1, 0, 0, 13, 1,  1, 1, 0, 0,  0, 0, 0, "R4 youngest int over fp wb");
    step(1, 2, 13, 1, 0, 0, 14, 1,  1, 1, 1, 0,  0, 0, 0, "R3 int1 exec fwd");
    step(1, 0, 14, 1, 0, 0, 15, 1,  0, 0, 0, 0,  0, 0, 0, "R2 fp E1 raw stall");
    step(1, 0, 14, 1, 0, 0, 15, 1,  0, 0, 0, 0,  0, 0, 0, "R2 fp E2 raw stall");
    step(1, 0, 14, 1, 0, 0, 15, 1,  0, 0, 0, 0,  0, 0, 0, "R2 fp E3 raw stall");
    step(1, 0, 14, 1, 0, 0, 15, 1,  1, 1, 2, 0,  0, 0, 0, "R3 fp E4 fwd");
    step(1, 3, 15, 1, 14, 1, 0, 1,  1, 1, 0, 0,  1, 2, 1, "R3 fp wb fwd on b");
    step(1, 4,  0, 1, 0, 0, 16, 0,  1, 0, 0, 0,  0, 0, 0, "R6 reg0 never tracked");
    step(1, 0, 16, 1, 0, 0, 17, 1,  1, 0, 0, 0,  0, 0, 0, "R6 no-write not tracked");
    step(1, 4,  0, 0, 0, 0, 18, 1,  1, 0, 0, 0,  0, 0, 0, "R8 issue mem1");
    step(1, 0,  0, 0, 0, 0, 18, 1,  0, 0, 0, 0,  0, 0, 0, "R5 waw mem E1");
    step(1, 0,  0, 0, 0, 0, 18, 1,  1, 0, 0, 0,  0, 0, 0, "R5 mem E2 clear");
    step(1, 1,  0, 0, 0, 0, 18, 1,  1, 0, 0, 0,  0, 0, 0, "R5 int never waw");
    step(0, 0, 18, 1, 0, 0,  0, 0,  1, 1, 1, 0,  0, 0, 0, "R4 youngest int1 exec over int0 wb");
    step(1, 0, 18, 1, 0, 0, 19, 1,  1, 1, 1, 1,  0, 0, 0, "R7 idle cycle advanced int1 to wb");
    @(posedge clk); #2 rr_valid = 1'b0;
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule